// File: doc/BRIEF.md
# Vector Complex Multiply-Accumulate Unit

A two-stage pipelined arithmetic unit for eight-lane vectors of signed 16-bit elements. Each issued operation multiplies two operand vectors lane by lane. The products are then used in one of four ways: returned directly, combined into the real part or the imaginary part of a complex product, or added into one of four wide per-lane accumulators that the block owns. A complex number sits in a lane pair: the even lane holds the real part and the odd lane the imaginary part. A vector therefore carries four complex values.

A complex multiply is issued as two operations. The real operation comes first. Its 40-bit result vector is fed back on the third operand input of the imaginary operation. That operation keeps the real parts in the even lanes and writes the imaginary parts into the odd lanes, so the output is a packed complex vector. A new operation may be issued on every cycle. Each result appears exactly two clock edges after issue, in issue order. Accumulators are read in the first stage and written in the second. A multiply-accumulate that directly follows another one to the same accumulator receives the pending sum through a bypass.

Top module: `vcmac_unit`

## Requirements
- R1: While rst_ni is low and after its release, valid_o and res_o are 0 and all four accumulators hold 0, whatever the other inputs do during reset.
- R2: An operation sampled with valid_i high on a rising edge shows on valid_o and res_o after the second following rising edge. Operations come out in issue order, one per cycle. When valid_o is low, res_o is all zero. An edge with valid_i low yields no result and changes no accumulator.
- R3: op_i = 3'b000 (multiply): output lane i (res_o bits 40i+39:40i) is the signed product of a_i lane i and b_i lane i (bits 16i+15:16i), sign-extended to 40 bits.
- R4: op_i = 3'b001 (complex real): for each pair k, output lane 2k is a[2k]*b[2k] - a[2k+1]*b[2k+1], sign-extended to 40 bits. Output lane 2k+1 is zero.
- R5: op_i = 3'b010 (complex imaginary): output lane 2k+1 is a[2k]*b[2k+1] + a[2k+1]*b[2k], sign-extended to 40 bits. Output lane 2k is c_i lane 2k (bits 80k+39:80k), passed unchanged.
- R6: op_i = 3'b011 (multiply-accumulate): each lane of the accumulator chosen by acc_sel_i gets the sign-extended lane product added to it. The output is the updated accumulator vector.
- R7: Accumulator lanes wrap modulo 2^40 on overflow, with no saturation.
- R8: Multiply-accumulates issued on consecutive cycles to the same accumulator each see the sum left by the one before.
- R9: Operations other than multiply-accumulate, cycles with valid_i low, and multiply-accumulates to another accumulator leave an accumulator unchanged.
- R10: Codes 3'b100 to 3'b111 produce a valid all-zero result and modify no accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Issue strobe for the operation on the other inputs |
| op_i | input | 3 | Operation code |
| acc_sel_i | input | 2 | Accumulator index for multiply-accumulate (bit 1 picks the pair) |
| a_i | input | 128 | First operand, eight 16-bit signed lanes |
| b_i | input | 128 | Second operand, eight 16-bit signed lanes |
| c_i | input | 320 | Third operand: earlier real result, eight 40-bit lanes |
| res_o | output | 320 | Result, eight 40-bit lanes |
| valid_o | output | 1 | Result valid |

## Verification
Extreme operands (-32768 squared, -32768 times 32767) show whether products are signed and fully widened. Cross sums reaching 2^31 in the imaginary operation tell a 40-bit sum apart from a 32-bit one. Random complex vectors with distinct values in every lane expose swapped real and imaginary lanes or wrong pair indexing. Runs of back-to-back accumulates to one accumulator, interleaved accumulates to others, gaps with valid_i low and reserved codes separate a working bypass from a stale read and from stray accumulator writes. A long run of maximal products drives one accumulator through its 40-bit wrap.

// File: rtl/vcmac_pkg.sv
package vcmac_pkg;
  localparam logic [2:0] OP_MUL = 3'b000;
  localparam logic [2:0] OP_CRE = 3'b001;
  localparam logic [2:0] OP_CIM = 3'b010;
  localparam logic [2:0] OP_MAC = 3'b011;
endpackage

// File: rtl/vcmac_pair_mul.sv
// Stage-1 multipliers for one complex lane pair: straight and cross products.
module vcmac_pair_mul #(
  parameter int unsigned DW = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [DW-1:0]       re_a_i,
  input  logic [DW-1:0]       im_a_i,
  input  logic [DW-1:0]       re_b_i,
  input  logic [DW-1:0]       im_b_i,
  output logic [2*DW-1:0]     rr_o,
  output logic [2*DW-1:0]     ii_o,
  output logic [2*DW-1:0]     ri_o,
  output logic [2*DW-1:0]     ir_o
);
  localparam int unsigned PW = 2 * DW;

  logic signed [PW-1:0] rr_d, ii_d, ri_d, ir_d;

  always_comb begin
    rr_d = PW'($signed(re_a_i) * $signed(re_b_i));
    ii_d = PW'($signed(im_a_i) * $signed(im_b_i));
    ri_d = PW'($signed(re_a_i) * $signed(im_b_i));
    ir_d = PW'($signed(im_a_i) * $signed(re_b_i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rr_o <= '0;
      ii_o <= '0;
      ri_o <= '0;
      ir_o <= '0;
    end else begin
      rr_o <= rr_d;
      ii_o <= ii_d;
      ri_o <= ri_d;
      ir_o <= ir_d;
    end
  end
endmodule

// File: rtl/vcmac_acc_bank.sv
// Accumulator bank: combinational read with bypass of the same-cycle write.
module vcmac_acc_bank #(
  parameter int unsigned LANES = 8,
  parameter int unsigned AW    = 40,
  parameter int unsigned NACC  = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [$clog2(NACC)-1:0]   rd_sel_i,
  input  logic                      wr_en_i,
  input  logic [$clog2(NACC)-1:0]   wr_sel_i,
  input  logic [LANES*AW-1:0]       wr_data_i,
  output logic [LANES*AW-1:0]       rd_data_o
);
  localparam int unsigned VW = LANES * AW;

  logic [VW-1:0] acc_q [NACC];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int n = 0; n < NACC; n++) acc_q[n] <= '0;
    end else if (wr_en_i) begin
      acc_q[wr_sel_i] <= wr_data_i;
    end
  end

  always_comb begin
    if (wr_en_i && (wr_sel_i == rd_sel_i)) rd_data_o = wr_data_i;
    else                                   rd_data_o = acc_q[rd_sel_i];
  end

  p_acc_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> acc_q[$past(wr_sel_i)] == $past(wr_data_i));

  for (genvar g = 0; g < NACC; g++) begin : g_hold
    p_acc_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(wr_en_i && (wr_sel_i == g)) |=> $stable(acc_q[g]));
  end
endmodule

// File: rtl/vcmac_unit.sv
module vcmac_unit
  import vcmac_pkg::*;
#(
  parameter int unsigned LANES = 8,
  parameter int unsigned DW    = 16,
  parameter int unsigned AW    = 40,
  parameter int unsigned NACC  = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic [2:0]               op_i,
  input  logic [$clog2(NACC)-1:0]  acc_sel_i,
  input  logic [LANES*DW-1:0]      a_i,
  input  logic [LANES*DW-1:0]      b_i,
  input  logic [LANES*AW-1:0]      c_i,
  output logic [LANES*AW-1:0]      res_o,
  output logic                     valid_o
);
  localparam int unsigned PAIRS = LANES / 2;
  localparam int unsigned PW    = 2 * DW;
  localparam int unsigned SELW  = $clog2(NACC);
  localparam int unsigned VW    = LANES * AW;

  function automatic logic [AW-1:0] sx(input logic [PW-1:0] p);
    return {{(AW-PW){p[PW-1]}}, p};
  endfunction

  // stage 1 state
  logic            s1_valid;
  logic [2:0]      s1_op;
  logic [SELW-1:0] s1_sel;
  logic [VW-1:0]   s1_c;
  logic [VW-1:0]   s1_acc;
  logic [PW-1:0]   rr [PAIRS];
  logic [PW-1:0]   ii [PAIRS];
  logic [PW-1:0]   ri [PAIRS];
  logic [PW-1:0]   ir [PAIRS];

  for (genvar k = 0; k < PAIRS; k++) begin : g_pair
    vcmac_pair_mul #(.DW(DW)) u_mul (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .re_a_i (a_i[(2*k)*DW +: DW]),
      .im_a_i (a_i[(2*k+1)*DW +: DW]),
      .re_b_i (b_i[(2*k)*DW +: DW]),
      .im_b_i (b_i[(2*k+1)*DW +: DW]),
      .rr_o   (rr[k]),
      .ii_o   (ii[k]),
      .ri_o   (ri[k]),
      .ir_o   (ir[k])
    );
  end

  // stage 2 combine
  logic [AW-1:0] lane_res [LANES];
  logic [AW-1:0] lane_sum [LANES];
  logic [VW-1:0] comb_res;
  logic [VW-1:0] mac_sum;
  logic [VW-1:0] acc_rd;
  logic          acc_wr;

  always_comb begin
    for (int k = 0; k < PAIRS; k++) begin
      lane_sum[2*k]   = s1_acc[(2*k)*AW +: AW]   + sx(rr[k]);
      lane_sum[2*k+1] = s1_acc[(2*k+1)*AW +: AW] + sx(ii[k]);
      unique case (s1_op)
        OP_MUL: begin
          lane_res[2*k]   = sx(rr[k]);
          lane_res[2*k+1] = sx(ii[k]);
        end
        OP_CRE: begin
          lane_res[2*k]   = sx(rr[k]) - sx(ii[k]);
          lane_res[2*k+1] = '0;
        end
        OP_CIM: begin
          lane_res[2*k]   = s1_c[(2*k)*AW +: AW];
          lane_res[2*k+1] = sx(ri[k]) + sx(ir[k]);
        end
        OP_MAC: begin
          lane_res[2*k]   = lane_sum[2*k];
          lane_res[2*k+1] = lane_sum[2*k+1];
        end
        default: begin
          lane_res[2*k]   = '0;
          lane_res[2*k+1] = '0;
        end
      endcase
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_flat
    assign comb_res[i*AW +: AW] = lane_res[i];
    assign mac_sum[i*AW +: AW]  = lane_sum[i];
  end

  assign acc_wr = s1_valid && (s1_op == OP_MAC);

  vcmac_acc_bank #(.LANES(LANES), .AW(AW), .NACC(NACC)) u_acc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_sel_i  (acc_sel_i),
    .wr_en_i   (acc_wr),
    .wr_sel_i  (s1_sel),
    .wr_data_i (mac_sum),
    .rd_data_o (acc_rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid <= 1'b0;
      s1_op    <= '0;
      s1_sel   <= '0;
      s1_c     <= '0;
      s1_acc   <= '0;
      valid_o  <= 1'b0;
      res_o    <= '0;
    end else begin
      s1_valid <= valid_i;
      s1_op    <= op_i;
      s1_sel   <= acc_sel_i;
      s1_c     <= c_i;
      s1_acc   <= acc_rd;
      valid_o  <= s1_valid;
      res_o    <= s1_valid ? comb_res : '0;
    end
  end

  p_issue_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> s1_valid);
  p_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !s1_valid);
  p_drain_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s1_valid |=> valid_o);
  p_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !s1_valid |=> (!valid_o && res_o == '0));
  p_rsv_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_valid && s1_op[2]) |=> res_o == '0);
  p_fwd_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_wr && valid_i && op_i == OP_MAC && acc_sel_i == s1_sel)
      |=> s1_acc == $past(mac_sum));

  for (genvar k = 0; k < PAIRS; k++) begin : g_chk
    p_cre_odd_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (s1_valid && s1_op == OP_CRE) |=> res_o[(2*k+1)*AW +: AW] == '0);
    p_cim_even_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (s1_valid && s1_op == OP_CIM)
        |=> res_o[(2*k)*AW +: AW] == $past(s1_c[(2*k)*AW +: AW]));
  end
endmodule

// File: tb/sim_vcmac_unit.sv
`timescale 1ns/1ps
module sim_vcmac_unit;
  localparam int L = 8;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic [2:0]   op_i = '0;
  logic [1:0]   acc_sel_i = '0;
  logic [127:0] a_i = '0;
  logic [127:0] b_i = '0;
  logic [319:0] c_i = '0;
  logic [319:0] res_o;
  logic         valid_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference state: accumulators and a two-deep queue of expected outputs
  logic [39:0]  macc [4][L];
  bit           exp_v   [2];
  logic [319:0] exp_res [2];
  string        exp_tag [2];

  always #2 clk_i = ~clk_i;

  vcmac_unit u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .acc_sel_i(acc_sel_i), .a_i(a_i), .b_i(b_i), .c_i(c_i),
    .res_o(res_o), .valid_o(valid_o)
  );

  function automatic longint el(input logic [127:0] x, input int i);
    logic signed [15:0] v;
    v = x[16*i +: 16];
    return longint'(v);
  endfunction

  function automatic logic [39:0] t40(input longint v);
    logic [63:0] w;
    w = v;
    return w[39:0];
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  function automatic logic [319:0] rnd320();
    return {$urandom, $urandom, $urandom, $urandom, $urandom,
            $urandom, $urandom, $urandom, $urandom, $urandom};
  endfunction

  function automatic string tag_of(input logic [2:0] op);
    case (op)
      3'b000: return "R3";
      3'b001: return "R4";
      3'b010: return "R5";
      3'b011: return "R6";
      default: return "R10";
    endcase
  endfunction

  task automatic model(input logic [2:0] op, input int sel, input logic [127:0] a,
                       input logic [127:0] b, input logic [319:0] c,
                       output logic [319:0] r);
    r = '0;
    for (int k = 0; k < L/2; k++) begin
      longint ar = el(a, 2*k);
      longint ai = el(a, 2*k+1);
      longint br = el(b, 2*k);
      longint bi = el(b, 2*k+1);
      case (op)
        3'b000: begin
          r[80*k +: 40]    = t40(ar*br);
          r[80*k+40 +: 40] = t40(ai*bi);
        end
        3'b001: r[80*k +: 40] = t40(ar*br - ai*bi);
        3'b010: begin
          r[80*k +: 40]    = c[80*k +: 40];
          r[80*k+40 +: 40] = t40(ar*bi + ai*br);
        end
        3'b011: begin
          macc[sel][2*k]   = macc[sel][2*k]   + t40(ar*br);
          macc[sel][2*k+1] = macc[sel][2*k+1] + t40(ai*bi);
          r[80*k +: 40]    = macc[sel][2*k];
          r[80*k+40 +: 40] = macc[sel][2*k+1];
        end
        default: ;
      endcase
    end
  endtask

  task automatic check_out();
    checks++;
    if (valid_o !== exp_v[1] || res_o !== exp_res[1]) begin
      errors++;
      $display("FAIL %s: valid=%0b res=%h expected valid=%0b res=%h",
               exp_tag[1], valid_o, res_o, exp_v[1], exp_res[1]);
    end
  endtask

  task automatic issue(input bit v, input logic [2:0] op, input int sel,
                       input logic [127:0] a, input logic [127:0] b,
                       input logic [319:0] c, input string tag);
    logic [319:0] r;
    @(negedge clk_i);
    check_out();
    r = '0;
    if (v) model(op, sel, a, b, c, r);
    exp_v[1] = exp_v[0];  exp_res[1] = exp_res[0];  exp_tag[1] = exp_tag[0];
    exp_v[0] = v;         exp_res[0] = r;           exp_tag[0] = tag;
    valid_i = v; op_i = op; acc_sel_i = sel[1:0]; a_i = a; b_i = b; c_i = c;
  endtask

  initial begin
    for (int s = 0; s < 4; s++) for (int i = 0; i < L; i++) macc[s][i] = '0;
    for (int j = 0; j < 2; j++) begin exp_v[j] = 0; exp_res[j] = '0; exp_tag[j] = "R2"; end

    // R1: outputs stay at zero during reset even with activity on the inputs
    valid_i = 1'b1; op_i = 3'b011; a_i = {8{16'h7fff}}; b_i = {8{16'h7fff}};
    repeat (3) begin
      @(negedge clk_i);
      checks++;
      if (valid_o !== 1'b0 || res_o !== '0) begin
        errors++;
        $display("FAIL R1: valid=%0b res=%h expected valid=0 res=0", valid_o, res_o);
      end
    end
    valid_i = 1'b0; op_i = '0; a_i = '0; b_i = '0;
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R1: every accumulator reads back zero after reset
    for (int s = 0; s < 4; s++) issue(1, 3'b011, s, '0, '0, '0, "R1");

    // R3: multiply corners and random
    issue(1, 3'b000, 0, {8{16'h8000}}, {8{16'h8000}}, '0, "R3");
    issue(1, 3'b000, 0, {8{16'h8000}}, {8{16'h7fff}}, '0, "R3");
    issue(1, 3'b000, 0, {8{16'hffff}}, {8{16'h0001}}, '0, "R3");
    for (int n = 0; n < 6; n++) issue(1, 3'b000, 0, rnd128(), rnd128(), rnd320(), "R3");

    // R4 / R5: complex halves, with a chained pair using the real result as c
    issue(1, 3'b001, 0, {8{16'h8000}}, {4{16'h7fff, 16'h8000}}, '0, "R4");
    issue(1, 3'b010, 0, {8{16'h8000}}, {8{16'h8000}}, rnd320(), "R5");
    for (int n = 0; n < 6; n++) begin
      logic [127:0] a = rnd128();
      logic [127:0] b = rnd128();
      logic [319:0] rr;
      issue(1, 3'b001, 0, a, b, rnd320(), "R4");
      rr = exp_res[0];
      issue(1, 3'b010, 0, a, b, rr, "R5");
    end

    // R8: back-to-back accumulates to one accumulator, then interleaved
    for (int n = 0; n < 5; n++) issue(1, 3'b011, 0, rnd128(), rnd128(), '0, "R8");
    for (int n = 0; n < 6; n++) issue(1, 3'b011, 1 + (n % 2), rnd128(), rnd128(), '0, "R6");

    // R9: non-accumulate ops, idle slots and other selectors leave accumulator 0 alone
    issue(1, 3'b000, 0, rnd128(), rnd128(), '0, "R9");
    issue(0, 3'b011, 0, rnd128(), rnd128(), '0, "R2");
    issue(1, 3'b001, 0, rnd128(), rnd128(), '0, "R9");
    issue(1, 3'b011, 3, rnd128(), rnd128(), '0, "R9");
    issue(1, 3'b011, 0, '0, '0, '0, "R9");

    // R10: reserved codes give zero and touch no accumulator
    for (int n = 4; n < 8; n++) issue(1, n[2:0], 0, rnd128(), rnd128(), rnd320(), "R10");
    issue(1, 3'b011, 0, '0, '0, '0, "R10");

    // R2: random mix with gaps
    for (int n = 0; n < 400; n++) begin
      bit v = ($urandom % 4) != 0;
      logic [2:0] op = 3'($urandom % 8);
      issue(v, op, $urandom % 4, rnd128(), rnd128(), rnd320(), v ? tag_of(op) : "R2");
    end

    // R7: drive accumulator 3 through its 40-bit wrap
    for (int n = 0; n < 540; n++)
      issue(1, 3'b011, 3, {8{16'h8000}}, {8{16'h8000}}, '0, "R7");
    issue(1, 3'b011, 3, '0, '0, '0, "R7");

    repeat (2) issue(0, 3'b000, 0, '0, '0, '0, "R2");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule